// File: doc/BRIEF.md
# Packed Signed Lane Arithmetic Unit

This block is a registered vector datapath for 128-bit operands split into lanes of 8, 16 or 32 bits. An opcode byte picks one of three lane-wise operations: a 16-bit fixed-point multiply that keeps the rounded, rescaled high part of the product, a sign transfer that applies the sign of one operand to the other, and an absolute value whose result is read as an unsigned number. Operand A acts as the multiplier or the sign control. Operand B is the data.

A lane-size select travels with the opcode and must agree with the lane width that the opcode implies. The result, an illegal-operation flag and a result-valid strobe are captured in one output register on the clock edge that samples the input strobe. When no strobe is present the register holds its contents, so a consumer can read the last result at any later time.

Top module: `lane_arith_unit`

## Requirements
- R1: Opcode 0x0B with lane select 01 computes, for each of the eight 16-bit lanes, the signed 32-bit product of the A and B lanes, shifts it right by 14, adds 1, shifts right by 1 and keeps the low 16 bits.
- R2: In the multiply operation, 0x8000 times 0x8000 gives 0x8000 in that lane, with no saturation.
- R3: In sign transfer, a lane whose A value is negative returns the two's-complement negation of its B lane; negating the most negative value returns the same bit pattern.
- R4: In sign transfer, a positive A lane returns the B lane unchanged and a zero A lane returns zero.
- R5: Sign transfer uses opcode 0x08 with lane select 00 (8-bit lanes), 0x09 with 01 (16-bit lanes) and 0x0A with 10 (32-bit lanes).
- R6: Absolute value on B uses opcode 0x1C/0x1D/0x1E with lane select 00/01/10; a lane with its top bit set is negated and any other lane passes, so the most negative value returns its own pattern.
- R7: result, illegal and out_valid take the values for a strobed input one clock edge after in_valid is sampled high; out_valid is low after an edge that sampled in_valid low.
- R8: After an edge that sampled in_valid low, result and illegal keep their previous values.
- R9: Any other opcode, or a lane select that does not match the opcode as listed in R1, R5 and R6, gives an all-zero result with illegal high; a legal operation gives illegal low.
- R10: While rst_n is low, out_valid, illegal and result are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Strobe: capture this cycle's operation |
| opcode | input | 8 | Operation code |
| lane_sel | input | 2 | Lane width: 00 8-bit, 01 16-bit, 10 32-bit |
| op_a | input | 128 | Multiplier or sign-control operand |
| op_b | input | 128 | Data operand |
| out_valid | output | 1 | High for one cycle per captured operation |
| result | output | 128 | Registered lane-wise result |
| illegal | output | 1 | Registered flag for an unsupported combination |

## Verification
Every operation's result, illegal flag and valid strobe are due exactly one rising edge after the strobe is sampled, so the driver applies each operation at a falling edge and queues the expected outcome, and the monitor pops the queue at the following falling edge whenever out_valid is high. On falling edges where out_valid is low, the monitor compares result and illegal against the last popped item to confirm they held. Expected values come from an arithmetic model in the bench that uses floor division for the multiply rounding and per-lane integer arithmetic for sign transfer and absolute value.

// File: rtl/lane_arith_pkg.sv
package lane_arith_pkg;

    typedef enum logic [1:0] {
        LSEL_8  = 2'b00,
        LSEL_16 = 2'b01,
        LSEL_32 = 2'b10,
        LSEL_RSV = 2'b11
    } lane_sel_e;

    typedef enum logic [1:0] {
        KIND_NONE  = 2'd0,
        KIND_MULHR = 2'd1,
        KIND_SIGN  = 2'd2,
        KIND_ABS   = 2'd3
    } op_kind_e;

    localparam logic [7:0] OPC_SIGN_8   = 8'h08;
    localparam logic [7:0] OPC_SIGN_16  = 8'h09;
    localparam logic [7:0] OPC_SIGN_32  = 8'h0A;
    localparam logic [7:0] OPC_MULHR_16 = 8'h0B;
    localparam logic [7:0] OPC_ABS_8    = 8'h1C;
    localparam logic [7:0] OPC_ABS_16   = 8'h1D;
    localparam logic [7:0] OPC_ABS_32   = 8'h1E;

    localparam int NUM_WIDTHS = 3;

endpackage

// File: rtl/lane_arith_decode.sv
module lane_arith_decode
    import lane_arith_pkg::*;
(
    input  logic [7:0] opcode,
    input  logic [1:0] lane_sel,
    output op_kind_e   kind,
    output logic [1:0] width_idx,
    output logic       bad_op
);

    logic [1:0] need_sel;
    op_kind_e   kind_raw;

    always_comb begin
        kind_raw = KIND_NONE;
        need_sel = LSEL_RSV;
        unique case (opcode)
            OPC_SIGN_8:   begin kind_raw = KIND_SIGN;  need_sel = LSEL_8;  end
            OPC_SIGN_16:  begin kind_raw = KIND_SIGN;  need_sel = LSEL_16; end
            OPC_SIGN_32:  begin kind_raw = KIND_SIGN;  need_sel = LSEL_32; end
            OPC_MULHR_16: begin kind_raw = KIND_MULHR; need_sel = LSEL_16; end
            OPC_ABS_8:    begin kind_raw = KIND_ABS;   need_sel = LSEL_8;  end
            OPC_ABS_16:   begin kind_raw = KIND_ABS;   need_sel = LSEL_16; end
            OPC_ABS_32:   begin kind_raw = KIND_ABS;   need_sel = LSEL_32; end
            default:      begin kind_raw = KIND_NONE;  need_sel = LSEL_RSV; end
        endcase
    end

    always_comb begin
        bad_op    = (kind_raw == KIND_NONE) || (lane_sel != need_sel);
        kind      = bad_op ? KIND_NONE : kind_raw;
        width_idx = bad_op ? 2'd0 : lane_sel;
    end

endmodule

// File: rtl/lane_arith_mulhr.sv
module lane_arith_mulhr #(
    parameter int VEC_W  = 128,
    parameter int LANE_W = 16
) (
    input  logic [VEC_W-1:0] a_i,
    input  logic [VEC_W-1:0] b_i,
    output logic [VEC_W-1:0] r_o
);

    localparam int LANES  = VEC_W / LANE_W;
    localparam int PROD_W = 2 * LANE_W;
    localparam int SHIFT  = LANE_W - 2;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic [LANE_W-1:0] a_l;
        logic [LANE_W-1:0] b_l;
        logic signed [PROD_W-1:0] a_x;
        logic signed [PROD_W-1:0] b_x;
        logic signed [PROD_W-1:0] prod;
        logic [LANE_W-1:0] r_l;

        always_comb begin
            a_l  = a_i[i*LANE_W +: LANE_W];
            b_l  = b_i[i*LANE_W +: LANE_W];
            a_x  = {{LANE_W{a_l[LANE_W-1]}}, a_l};
            b_x  = {{LANE_W{b_l[LANE_W-1]}}, b_l};
            prod = a_x * b_x;
            r_l  = LANE_W'(((prod >> SHIFT) + PROD_W'(1)) >> 1);
        end

        always_comb begin
            if (a_l == {1'b1, {(LANE_W-1){1'b0}}} && b_l == {1'b1, {(LANE_W-1){1'b0}}})
                AST_MIN_PRODUCT_WRAPS: assert (r_l == {1'b1, {(LANE_W-1){1'b0}}}) // R2
                    else $error("min by min lane did not wrap");
        end

        assign r_o[i*LANE_W +: LANE_W] = r_l;
    end

endmodule

// File: rtl/lane_arith_lanes.sv
module lane_arith_lanes #(
    parameter int VEC_W  = 128,
    parameter int LANE_W = 8
) (
    input  logic [VEC_W-1:0] a_i,
    input  logic [VEC_W-1:0] b_i,
    output logic [VEC_W-1:0] sign_o,
    output logic [VEC_W-1:0] abs_o
);

    localparam int LANES = VEC_W / LANE_W;
    localparam logic [LANE_W-1:0] MIN_VAL = {1'b1, {(LANE_W-1){1'b0}}};

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic [LANE_W-1:0] a_l;
        logic [LANE_W-1:0] b_l;
        logic [LANE_W-1:0] b_neg;
        logic [LANE_W-1:0] s_l;
        logic [LANE_W-1:0] m_l;

        always_comb begin
            a_l   = a_i[i*LANE_W +: LANE_W];
            b_l   = b_i[i*LANE_W +: LANE_W];
            b_neg = '0 - b_l;
            if (a_l == '0)
                s_l = '0;
            else if (a_l[LANE_W-1])
                s_l = b_neg;
            else
                s_l = b_l;
            m_l = b_l[LANE_W-1] ? b_neg : b_l;
        end

        always_comb begin
            if (a_l == '0)
                AST_ZERO_CONTROL_CLEARS: assert (s_l == '0) // R4
                    else $error("zero control lane gave nonzero");
            if (m_l[LANE_W-1])
                AST_ABS_TOPBIT_ONLY_MIN: assert (b_l == MIN_VAL) // R6
                    else $error("abs lane negative for non-minimum input");
        end

        assign sign_o[i*LANE_W +: LANE_W] = s_l;
        assign abs_o[i*LANE_W +: LANE_W]  = m_l;
    end

endmodule

// File: rtl/lane_arith_unit.sv
module lane_arith_unit
    import lane_arith_pkg::*;
#(
    parameter int VEC_W = 128
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [7:0]       opcode,
    input  logic [1:0]       lane_sel,
    input  logic [VEC_W-1:0] op_a,
    input  logic [VEC_W-1:0] op_b,
    output logic             out_valid,
    output logic [VEC_W-1:0] result,
    output logic             illegal
);

    localparam int MUL_LANE_W = 16;

    typedef struct packed {
        logic             vld;
        logic             ill;
        logic [VEC_W-1:0] res;
    } out_reg_t;

    out_reg_t st_d, st_q;

    op_kind_e   kind;
    logic [1:0] width_idx;
    logic       bad_op;

    logic [VEC_W-1:0] mul_res;
    logic [VEC_W-1:0] sign_all [NUM_WIDTHS];
    logic [VEC_W-1:0] abs_all  [NUM_WIDTHS];
    logic [VEC_W-1:0] op_res;

    lane_arith_decode u_dec (
        .opcode    (opcode),
        .lane_sel  (lane_sel),
        .kind      (kind),
        .width_idx (width_idx),
        .bad_op    (bad_op)
    );

    lane_arith_mulhr #(
        .VEC_W  (VEC_W),
        .LANE_W (MUL_LANE_W)
    ) u_mul (
        .a_i (op_a),
        .b_i (op_b),
        .r_o (mul_res)
    );

    for (genvar g = 0; g < NUM_WIDTHS; g++) begin : g_width
        lane_arith_lanes #(
            .VEC_W  (VEC_W),
            .LANE_W (8 << g)
        ) u_lanes (
            .a_i    (op_a),
            .b_i    (op_b),
            .sign_o (sign_all[g]),
            .abs_o  (abs_all[g])
        );
    end

    always_comb begin
        op_res = '0;
        unique case (kind)
            KIND_MULHR: op_res = mul_res;
            KIND_SIGN:  op_res = (width_idx < 2'(NUM_WIDTHS)) ? sign_all[width_idx] : '0;
            KIND_ABS:   op_res = (width_idx < 2'(NUM_WIDTHS)) ? abs_all[width_idx]  : '0;
            default:    op_res = '0;
        endcase
    end

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_valid;
        if (in_valid) begin
            st_d.ill = bad_op;
            st_d.res = bad_op ? '0 : op_res;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign out_valid = st_q.vld;
    assign result    = st_q.res;
    assign illegal   = st_q.ill;

    AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid) // R7
        else $error("out_valid missing after strobe");

    AST_VALID_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid) // R7
        else $error("out_valid without strobe");

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(result) && $stable(illegal))) // R8
        else $error("output changed without strobe");

    AST_ILLEGAL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> (result == '0)) // R9
        else $error("illegal result not zero");

endmodule

// File: tb/lane_arith_unit_test.sv
module lane_arith_unit_test;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [7:0]   opcode = '0;
    logic [1:0]   lane_sel = '0;
    logic [127:0] op_a = '0;
    logic [127:0] op_b = '0;
    logic         out_valid;
    logic [127:0] result;
    logic         illegal;

    int checks = 0;
    int errors = 0;

    typedef struct {
        logic [127:0] res;
        logic         ill;
        string        tag;
    } exp_t;

    exp_t exp_q[$];
    logic [127:0] last_res = '0;
    logic         last_ill = 1'b0;
    bit           monitor_on = 1'b0;

    always #5 clk = ~clk;

    lane_arith_unit uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .opcode    (opcode),
        .lane_sel  (lane_sel),
        .op_a      (op_a),
        .op_b      (op_b),
        .out_valid (out_valid),
        .result    (result),
        .illegal   (illegal)
    );

    function automatic logic [128:0] model(logic [7:0] opc, logic [1:0] ls,
                                           logic [127:0] a, logic [127:0] b);
        logic [127:0] r = '0;
        int w = 0;
        int kind = 0;
        case (opc)
            8'h08: begin kind = 2; w = 8;  end
            8'h09: begin kind = 2; w = 16; end
            8'h0A: begin kind = 2; w = 32; end
            8'h0B: begin kind = 1; w = 16; end
            8'h1C: begin kind = 3; w = 8;  end
            8'h1D: begin kind = 3; w = 16; end
            8'h1E: begin kind = 3; w = 32; end
            default: kind = 0;
        endcase
        if (kind == 0 || (8 << ls) != w || ls == 2'b11)
            return {1'b1, 128'd0};
        for (int i = 0; i < 128 / w; i++) begin
            longint mask = (longint'(1) << w) - 1;
            longint al = longint'((a >> (i * w)) & 128'(mask));
            longint bl = longint'((b >> (i * w)) & 128'(mask));
            longint sa = (al >= (longint'(1) << (w - 1))) ? al - (longint'(1) << w) : al;
            longint sb = (bl >= (longint'(1) << (w - 1))) ? bl - (longint'(1) << w) : bl;
            longint v;
            if (kind == 1)
                v = (sa * sb + 16384) >>> 15;
            else if (kind == 2)
                v = (sa < 0) ? -sb : ((sa > 0) ? sb : 0);
            else
                v = (sb < 0) ? -sb : sb;
            r = r | (128'(v & mask) << (i * w));
        end
        return {1'b0, r};
    endfunction

    task automatic send(logic [7:0] opc, logic [1:0] ls,
                        logic [127:0] a, logic [127:0] b, string tag);
        logic [128:0] e;
        exp_t item;
        @(negedge clk);
        in_valid = 1'b1;
        opcode   = opc;
        lane_sel = ls;
        op_a     = a;
        op_b     = b;
        e = model(opc, ls, a, b);
        item.res = e[127:0];
        item.ill = e[128];
        item.tag = tag;
        exp_q.push_back(item);
    endtask

    task automatic idle(int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            in_valid = 1'b0;
            op_a     = {4{$urandom}};
            op_b     = {4{$urandom}};
            opcode   = 8'($urandom);
        end
    endtask

    function automatic logic [127:0] rnd128();
        return {$urandom, $urandom, $urandom, $urandom};
    endfunction

    always @(negedge clk) begin
        if (monitor_on) begin
            if (out_valid) begin
                checks++;
                if (exp_q.size() == 0) begin
                    errors++;
                    $display("FAIL R7: out_valid=1 with no pending operation, expected 0");
                end else begin
                    exp_t it;
                    it = exp_q.pop_front();
                    if (result !== it.res || illegal !== it.ill) begin
                        errors++;
                        $display("FAIL %s: result=%h illegal=%b expected result=%h illegal=%b",
                                 it.tag, result, illegal, it.res, it.ill);
                    end
                    last_res = it.res;
                    last_ill = it.ill;
                end
            end else begin
                checks++;
                if (result !== last_res || illegal !== last_ill) begin
                    errors++;
                    $display("FAIL R8: idle result=%h illegal=%b expected result=%h illegal=%b",
                             result, illegal, last_res, last_ill);
                end
            end
        end
    end

    initial begin
        fork
            begin
                repeat (20000) @(posedge clk);
                errors++;
                $display("FAIL watchdog: run did not finish, expected completion");
                $display("Simulation finished: %0d checks, %0d errors", checks, errors);
                $finish;
            end
        join_none

        repeat (3) @(posedge clk);
        @(negedge clk);
        checks++;
        if (out_valid !== 1'b0 || result !== '0 || illegal !== 1'b0) begin
            errors++;
            $display("FAIL R10: reset out_valid=%b result=%h illegal=%b expected 0/0/0",
                     out_valid, result, illegal);
        end
        rst_n = 1'b1;
        monitor_on = 1'b1;

        // R1 directed: 0.5*0.5, max*max, -1*1, small values
        send(8'h0B, 2'b01, {16'h4000, 16'h7FFF, 16'hFFFF, 16'h0001, 16'h1234, 16'hC000, 16'h0000, 16'h7FFF},
                           {16'h4000, 16'h7FFF, 16'h0001, 16'h0001, 16'hEDCC, 16'h4000, 16'h5555, 16'h8001}, "R1");
        // R2: min by min wraps
        send(8'h0B, 2'b01, {8{16'h8000}}, {8{16'h8000}}, "R2");
        idle(2);
        for (int n = 0; n < 20; n++) send(8'h0B, 2'b01, rnd128(), rnd128(), "R1");
        idle(1);

        // R3/R4/R5: sign transfer, each width
        send(8'h08, 2'b00, {16{8'hFF}}, {8{8'h80, 8'h05}}, "R3");
        send(8'h08, 2'b00, {8{8'h00, 8'h7F}}, {16{8'h93}}, "R4");
        send(8'h09, 2'b01, {4{16'h8000, 16'h0001}}, {4{16'h8000, 16'h1234}}, "R3");
        send(8'h09, 2'b01, {4{16'h0000, 16'h0042}}, {8{16'hBEEF}}, "R4");
        send(8'h0A, 2'b10, {32'hFFFFFFFF, 32'h00000000, 32'h7FFFFFFF, 32'h80000000},
                           {32'h00000001, 32'h12345678, 32'h87654321, 32'h80000000}, "R5");
        for (int n = 0; n < 10; n++) begin
            send(8'h08, 2'b00, rnd128(), rnd128(), "R5");
            send(8'h09, 2'b01, rnd128(), rnd128(), "R5");
            send(8'h0A, 2'b10, rnd128(), rnd128(), "R5");
        end
        idle(3);

        // R6: absolute value
        send(8'h1C, 2'b00, rnd128(), {4{8'h80, 8'h7F, 8'hFF, 8'h00}}, "R6");
        send(8'h1D, 2'b01, rnd128(), {2{16'h8000, 16'h7FFF, 16'hFFFE, 16'h0003}}, "R6");
        send(8'h1E, 2'b10, rnd128(), {32'h80000000, 32'hFFFFFFFF, 32'h7FFFFFFF, 32'h00000000}, "R6");
        for (int n = 0; n < 10; n++) begin
            send(8'h1C, 2'b00, rnd128(), rnd128(), "R6");
            send(8'h1D, 2'b01, rnd128(), rnd128(), "R6");
            send(8'h1E, 2'b10, rnd128(), rnd128(), "R6");
        end
        idle(2);

        // R9: unknown opcodes and mismatched lane selects, then a legal op clears the flag
        send(8'h55, 2'b01, rnd128(), rnd128(), "R9");
        idle(2);
        send(8'h08, 2'b01, rnd128(), rnd128(), "R9");
        send(8'h0B, 2'b00, rnd128(), rnd128(), "R9");
        send(8'h1E, 2'b11, rnd128(), rnd128(), "R9");
        send(8'h0A, 2'b10, rnd128(), rnd128(), "R9");
        idle(4);
        for (int n = 0; n < 10; n++) begin
            send(8'($urandom), 2'($urandom), rnd128(), rnd128(), "R9");
            if (n % 3 == 0) idle(1);
        end
        idle(3);

        checks++;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL R7: %0d results never appeared, expected 0", exp_q.size());
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule